// File: doc/BRIEF.md
# Parallel Display Strobe Timer

This block produces the chip-select, write-strobe, read-strobe and command/data select waveforms for an asynchronous parallel display bus. The bus is 8 or 16 bits wide. Two packed configuration words give the timing. Every strobe edge is a count of ticks, and a tick is one or two base clocks.

A requester presents a request and holds it until the block accepts it. The request carries a direction (read or write), a command/data flag and the write data. The block samples the configuration at acceptance and runs the access with a tick counter that starts at zero. For a read, it captures the bus at a programmed tick and returns the captured value with a one-clock valid pulse. The block takes no new request until the access length has passed. The access length covers both the cycle length and a minimum deassert time of the chip select.

Each pin has its own polarity inversion. These inversion inputs act at once, even during an access.

Top module: `par_strobe_timer`

## Requirements
- R1: While reset is held and after it is released, the block has no access in progress. All strobes are deasserted, `req_ready` is 1, `rd_valid` is 0 and `bus_oe` is 0.
- R2: Edge word `tim_edges` fields:
  - bits 3:0 give the chip-select on tick; bits 9:4 give the chip-select off tick.
  - bits 13:10 give the write-strobe on tick; bits 19:14 give the write-strobe off tick.
  - bits 23:20 give the read-strobe on tick; bits 29:24 give the read-strobe off tick.
- R3: Cycle word `tim_cycle` fields:
  - bits 5:0 give the write cycle length in ticks; bits 11:6 give the read cycle length in ticks.
  - bits 17:12 give the minimum chip-select deassert width in ticks.
  - bits 27:22 give the read sample tick.
  - bits 21:18 have no effect.
- R4: Tick t counts from 0 at acceptance. A strobe is asserted exactly while on <= t < off. Chip select is used for every access. The write strobe is used only in writes and the read strobe only in reads.
- R5: With `tick_x2`=1 at acceptance, every tick lasts two clocks; with 0 it lasts one clock.
- R6: An access lasts max(cycle length, CS-off + deassert width) ticks. `req_ready` is 0 from the clock after acceptance until that time has passed. A request is accepted only on an edge where `req_ready` is 1.
- R7: During a read, `bus_din` is captured on the first clock of tick = sample tick. `rd_data` holds that value until the next capture.
- R8: After a read, `rd_valid` is 1 for exactly one clock: the first clock in which `req_ready` is back at 1. A request presented in that clock is accepted.
- R9: The command/data line carries logical 0 for a command (`req_cmd`=1) and logical 1 for data. It is held from acceptance until the next acceptance, and is logical 1 after reset.
- R10: Each pin of `bus_cs`, `bus_we` and `bus_re` equals its default level XOR its inversion input. The default level is low when asserted and high when idle. `bus_dc` equals its logical level XOR `inv_dc`. The inversion inputs act immediately, also during an access.
- R11: With `bus_wide`=0 at acceptance, only the low 8 bits are used. `bus_dout[15:8]` is 0, and `rd_data[15:8]` is captured as 0.
- R12: During a write access, `bus_oe` is 1 and `bus_dout` carries the accepted write data. `bus_oe` is 0 for reads and when idle.
- R13: Changing `tim_edges`, `tim_cycle`, `tick_x2` or `bus_wide` during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_edges | input | 30 | Packed strobe on/off ticks (R2) |
| tim_cycle | input | 28 | Packed cycle, deassert width and sample ticks (R3) |
| tick_x2 | input | 1 | Tick lasts two clocks when 1 |
| bus_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| inv_cs | input | 1 | Invert chip-select pin |
| inv_we | input | 1 | Invert write-strobe pin |
| inv_re | input | 1 | Invert read-strobe pin |
| inv_dc | input | 1 | Invert command/data pin |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1: read access, 0: write access |
| req_cmd | input | 1 | 1: command access, 0: data access |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block can accept a request |
| bus_din | input | 16 | Data from the display bus |
| bus_cs | output | 1 | Chip-select pin |
| bus_we | output | 1 | Write-strobe pin |
| bus_re | output | 1 | Read-strobe pin |
| bus_dc | output | 1 | Command/data select pin |
| bus_dout | output | 16 | Data to the display bus |
| bus_oe | output | 1 | Data output enable |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-clock pulse at the end of a read |

## Verification
The end of a read and the start of the next access can fall in the same clock. In that clock `rd_valid` pulses and `req_ready` rises, and a waiting request is accepted at the next edge. The bench provokes this by keeping the next request valid while a read is still running, so that acceptance coincides with the valid pulse. A bench model keeps the elapsed clocks of each access. On every clock, the bench checks that the captured data, the valid pulse and the first strobe edges of the new access all appear in the expected cycles.

// File: rtl/par_strobe_timer.sv
module par_strobe_timer #(
  parameter int DW   = 16,
  parameter int NW   = 8,
  parameter int ONW  = 4,
  parameter int OFFW = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3*(ONW+OFFW)-1:0]    tim_edges,
  input  logic [4*OFFW+3:0]          tim_cycle,
  input  logic                       tick_x2,
  input  logic                       bus_wide,
  input  logic                       inv_cs,
  input  logic                       inv_we,
  input  logic                       inv_re,
  input  logic                       inv_dc,
  input  logic                       req_valid,
  input  logic                       req_read,
  input  logic                       req_cmd,
  input  logic [DW-1:0]              req_wdata,
  output logic                       req_ready,
  input  logic [DW-1:0]              bus_din,
  output logic                       bus_cs,
  output logic                       bus_we,
  output logic                       bus_re,
  output logic                       bus_dc,
  output logic [DW-1:0]              bus_dout,
  output logic                       bus_oe,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_valid
);
  localparam int EW      = 3*(ONW+OFFW);
  localparam int CW      = 4*OFFW+4;
  localparam int PAIR    = ONW+OFFW;
  localparam int ACC_LSB = 3*OFFW+4;
  localparam int TW      = OFFW+1;
  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic          busy, pre, is_rd, dc_q, wide_q, slow_q, rdv_q;
  logic [EW-1:0] e_q;
  logic [CW-1:0] c_q;
  logic [DW-1:0] wd_q, rd_q;
  logic [TW-1:0] t;

  wire accept = req_valid && !busy;

  wire [TW-1:0] cs_on  = TW'(e_q[ONW-1:0]);
  wire [TW-1:0] cs_off = TW'(e_q[ONW +: OFFW]);
  wire [TW-1:0] we_on  = TW'(e_q[PAIR +: ONW]);
  wire [TW-1:0] we_off = TW'(e_q[PAIR+ONW +: OFFW]);
  wire [TW-1:0] re_on  = TW'(e_q[2*PAIR +: ONW]);
  wire [TW-1:0] re_off = TW'(e_q[2*PAIR+ONW +: OFFW]);
  wire [TW-1:0] wcyc   = TW'(c_q[0 +: OFFW]);
  wire [TW-1:0] rcyc   = TW'(c_q[OFFW +: OFFW]);
  wire [TW-1:0] pw     = TW'(c_q[2*OFFW +: OFFW]);
  wire [TW-1:0] acc    = TW'(c_q[ACC_LSB +: OFFW]);

  wire [TW-1:0] cyc_len = is_rd ? rcyc : wcyc;
  wire [TW-1:0] cs_hold = cs_off + pw;
  wire [TW-1:0] t_end   = (cyc_len > cs_hold) ? cyc_len : cs_hold;
  wire          tick_dn = !slow_q || pre;
  wire          last    = busy && tick_dn && (t + 1'b1 == t_end);
  wire [DW-1:0] lane    = wide_q ? {DW{1'b1}} : NMASK;

  wire cs_act = busy && (t >= cs_on) && (t < cs_off);
  wire we_act = busy && !is_rd && (t >= we_on) && (t < we_off);
  wire re_act = busy &&  is_rd && (t >= re_on) && (t < re_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pre    <= 1'b0;
      t      <= '0;
      is_rd  <= 1'b0;
      dc_q   <= 1'b1;
      wide_q <= 1'b1;
      slow_q <= 1'b0;
      e_q    <= '0;
      c_q    <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      pre    <= 1'b0;
      t      <= '0;
      is_rd  <= req_read;
      dc_q   <= !req_cmd;
      wide_q <= bus_wide;
      slow_q <= tick_x2;
      e_q    <= tim_edges;
      c_q    <= tim_cycle;
      wd_q   <= req_wdata;
    end else if (busy) begin
      if (tick_dn) begin
        pre <= 1'b0;
        if (last) busy <= 1'b0;
        else      t    <= t + 1'b1;
      end else begin
        pre <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      rdv_q <= 1'b0;
    end else begin
      rdv_q <= last && is_rd;
      if (busy && is_rd && !pre && t == acc) rd_q <= bus_din & lane;
    end
  end

  assign req_ready = !busy;
  assign bus_cs    = !cs_act ^ inv_cs;
  assign bus_we    = !we_act ^ inv_we;
  assign bus_re    = !re_act ^ inv_re;
  assign bus_dc    = dc_q ^ inv_dc;
  assign bus_dout  = wd_q & lane;
  assign bus_oe    = busy && !is_rd;
  assign rd_data   = rd_q;
  assign rd_valid  = rdv_q;

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  rdv_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready);
  // R4
  no_we_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd) |-> !we_act);
  // R12
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !req_ready);
  // R5
  slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slow_q && !pre) |=> (busy && $stable(t)));
  // R13
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(e_q) && $stable(c_q) && $stable(slow_q)));
endmodule

// File: tb/par_strobe_timer_tb.sv
`timescale 1ns/1ps
module par_strobe_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [29:0] tim_edges = '0;
  logic [27:0] tim_cycle = '0;
  logic tick_x2 = 0, bus_wide = 1, inv_cs = 0, inv_we = 0, inv_re = 0, inv_dc = 0;
  logic req_valid = 0, req_read = 0, req_cmd = 0;
  logic [15:0] req_wdata = '0, bus_din = 16'h1234;
  logic req_ready, bus_cs, bus_we, bus_re, bus_dc, bus_oe, rd_valid;
  logic [15:0] bus_dout, rd_data;

  par_strobe_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tim_edges(tim_edges), .tim_cycle(tim_cycle),
    .tick_x2(tick_x2), .bus_wide(bus_wide), .inv_cs(inv_cs), .inv_we(inv_we),
    .inv_re(inv_re), .inv_dc(inv_dc), .req_valid(req_valid), .req_read(req_read),
    .req_cmd(req_cmd), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_din(bus_din), .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re),
    .bus_dc(bus_dc), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .rd_data(rd_data), .rd_valid(rd_valid));

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference model state
  bit m_busy = 0, m_rd = 0, m_dc = 1, m_wide = 1, m_rdv = 0;
  int m_n = 0, m_div = 1, m_tend = 1, m_acc = 0;
  int m_cson, m_csoff, m_weon, m_weoff, m_reon, m_reoff;
  logic [15:0] m_wd = '0, m_rdata = '0;

  function automatic logic [29:0] pe(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return {6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
  endfunction
  function automatic logic [27:0] pc(int wc, int rc, int pw, int ac);
    return {6'(ac), 4'hF, 6'(pw), 6'(rc), 6'(wc)}; // R3: bits 21:18 set, must be ignored
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; m_dc = 1; m_wide = 1; m_rdv = 0; m_wd = '0; m_rdata = '0;
    end else if (m_busy) begin
      if (m_rd && m_n == m_acc * m_div)
        m_rdata = m_wide ? bus_din : {8'h00, bus_din[7:0]};
      if (m_n + 1 == m_tend * m_div) begin
        m_busy = 0; m_rdv = m_rd;
      end else begin
        m_n++; m_rdv = 0;
      end
    end else begin
      m_rdv = 0;
      if (req_valid) begin
        int wc, rc, pw, cyl;
        // R2 field positions
        m_cson  = int'(tim_edges[3:0]);   m_csoff = int'(tim_edges[9:4]);
        m_weon  = int'(tim_edges[13:10]); m_weoff = int'(tim_edges[19:14]);
        m_reon  = int'(tim_edges[23:20]); m_reoff = int'(tim_edges[29:24]);
        // R3 field positions
        wc = int'(tim_cycle[5:0]); rc = int'(tim_cycle[11:6]);
        pw = int'(tim_cycle[17:12]); m_acc = int'(tim_cycle[27:22]);
        m_rd = req_read; m_dc = !req_cmd; m_wide = bus_wide;
        m_wd = req_wdata; m_div = tick_x2 ? 2 : 1; m_n = 0; m_busy = 1;
        cyl = m_rd ? rc : wc;
        m_tend = (cyl > m_csoff + pw) ? cyl : m_csoff + pw;
      end
    end
  end

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] %s actual=%h expected=%h t=%0t", req, phase, nm, act, exp, $time);
    end
  endtask

  function automatic bit inr(int t, int on, int off);
    return (t >= on) && (t < off);
  endfunction

  always @(negedge clk) begin
    bus_din <= bus_din * 16'd5 + 16'h3B1;
    if (rst_n && !done) begin
      int t;
      t = m_n / m_div;
      chk("R4", "bus_cs", 32'(bus_cs), 32'(!(m_busy && inr(t, m_cson, m_csoff)) ^ inv_cs));
      chk("R4", "bus_we", 32'(bus_we), 32'(!(m_busy && !m_rd && inr(t, m_weon, m_weoff)) ^ inv_we));
      chk("R4", "bus_re", 32'(bus_re), 32'(!(m_busy && m_rd && inr(t, m_reon, m_reoff)) ^ inv_re));
      chk("R9", "bus_dc", 32'(bus_dc), 32'(m_dc ^ inv_dc));
      chk("R12", "bus_oe", 32'(bus_oe), 32'(m_busy && !m_rd));
      chk("R12", "bus_dout", 32'(bus_dout), 32'(m_wide ? m_wd : {8'h00, m_wd[7:0]}));
      chk("R6", "req_ready", 32'(req_ready), 32'(!m_busy));
      chk("R8", "rd_valid", 32'(rd_valid), 32'(m_rdv));
      chk("R7", "rd_data", 32'(rd_data), 32'(m_rdata));
    end
  end

  task automatic send(bit rd, bit cmd, logic [15:0] wd);
    bit acc;
    req_read = rd; req_cmd = cmd; req_wdata = wd; req_valid = 1;
    do begin acc = !m_busy; @(negedge clk); end while (!acc);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 100000 && !done) begin
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cs idle", 32'(bus_cs), 32'd1);
    chk("R1", "ready", 32'(req_ready), 32'd1);
    chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
    chk("R1", "oe", 32'(bus_oe), 32'd0);
    chk("R9", "dc reset data", 32'(bus_dc), 32'd1);
    rst_n = 1;
    @(negedge clk);

    phase = "R2 R3 R4 R9 write cmd/data";
    tim_edges = pe(1, 8, 2, 6, 2, 7);
    tim_cycle = pc(9, 10, 2, 5);
    send(0, 1, 16'hC0DE); wait_idle();
    send(0, 0, 16'h5AA5); wait_idle();

    phase = "R7 read";
    send(1, 0, 16'h0); wait_idle();

    phase = "R5 slow tick";
    tick_x2 = 1;
    send(1, 1, 16'h0); wait_idle();
    send(0, 0, 16'hBEEF); wait_idle();
    tick_x2 = 0;

    phase = "R8 back-to-back";
    tim_edges = pe(0, 3, 0, 2, 0, 3);
    tim_cycle = pc(2, 3, 0, 1);
    send(1, 0, 16'h0);
    send(1, 1, 16'h0);
    send(0, 0, 16'h1111);
    send(1, 0, 16'h0);
    wait_idle();

    phase = "R6 cycle dominates";
    tim_edges = pe(0, 4, 1, 3, 1, 4);
    tim_cycle = pc(12, 20, 1, 3);
    send(1, 0, 16'h0); send(0, 1, 16'h2222); wait_idle();

    phase = "R6 max fields";
    tim_edges = pe(15, 63, 15, 63, 15, 63);
    tim_cycle = pc(63, 63, 63, 62);
    send(1, 0, 16'h0); wait_idle();

    phase = "R10 polarity live";
    tim_edges = pe(1, 10, 2, 8, 2, 9);
    tim_cycle = pc(10, 10, 3, 4);
    send(0, 1, 16'h7E7E);
    repeat (3) @(negedge clk);
    inv_cs = 1; inv_we = 1; inv_re = 1; inv_dc = 1;
    wait_idle();
    send(1, 0, 16'h0);
    repeat (4) @(negedge clk);
    inv_cs = 0; inv_re = 0;
    wait_idle();
    inv_we = 0; inv_dc = 0;

    phase = "R11 narrow bus";
    bus_wide = 0;
    send(0, 0, 16'hABCD); wait_idle();
    send(1, 0, 16'h0); wait_idle();
    bus_wide = 1;

    phase = "R13 config change mid-access";
    send(1, 0, 16'h0);
    tim_edges = pe(0, 1, 0, 1, 0, 1);
    tim_cycle = pc(1, 1, 0, 1);
    tick_x2 = 1; bus_wide = 0;
    wait_idle();
    tick_x2 = 0; bus_wide = 1;
    tim_edges = pe(1, 8, 2, 6, 2, 7);
    tim_cycle = pc(9, 10, 2, 5);
    send(1, 1, 16'h0); send(0, 0, 16'h3C3C); wait_idle();

    repeat (3) @(negedge clk);
    summary();
  end
endmodule